// File: doc/BRIEF.md
# Pointer-Addressed Load/Store Execution Unit

This block executes a subset of an 8-bit processor's instructions: memory loads and stores, register increments and decrements, byte moves between the accumulator and the halves of a register, and logical OR with memory. Its architectural state is a bank of sixteen 16-bit pointer registers, an 8-bit accumulator and two 4-bit selectors. One selector names the program pointer and the other names the index pointer. Every memory access takes its address from a pointer register. That register is picked by the low nibble of the opcode, by the index selector or by the program selector. Many instructions step that pointer up or down after the access.

Opcodes arrive on a valid/ready stream. The unit takes an opcode on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` then stays low for one execute cycle. In that cycle the unit drives the memory port and updates its state. It returns high at the next edge. A producer may hold `op_valid` high throughout; an opcode is never taken twice.

The memory answers reads combinationally within the execute cycle and commits a write at the end of it. One cycle after the execute cycle, `retire` pulses, and `bad_op` pulses with it when the opcode is not supported. `acc_d` shows the accumulator at all times. The two selectors are loaded through a side port.

Top module: `ptr_exec_unit`

## Requirements
- R1: After reset the accumulator, all sixteen pointer registers and both selectors are zero, `op_ready` is 1, and `retire` and `bad_op` are 0.
- R2: An opcode is accepted on an edge with `op_valid` and `op_ready` high. `op_ready` is 0 in the following (execute) cycle, so a held `op_valid` is not taken again. `retire` is high for exactly the one cycle after the execute cycle.
- R3: Opcode 0N with N nonzero loads the accumulator from memory at R(N). Opcode 4N does the same and then adds 1 to R(N).
- R4: Opcode F0 loads the accumulator from memory at R(X), where X is the index selector. Opcode 72 does the same and then adds 1 to R(X).
- R5: Opcode F8 loads the accumulator from memory at R(P), where P is the program selector, and adds 1 to R(P).
- R6: Opcode 5N writes the accumulator to memory at R(N). Opcode 73 writes it to memory at R(X) and then subtracts 1 from R(X). `mem_we` is high only in the execute cycle, and the address is the pointer value before any step.
- R7: Opcode 1N adds 1 to R(N), 2N subtracts 1 from R(N), and 60 adds 1 to R(X).
- R8: Opcodes 8N and 9N copy bits 7:0 and bits 15:8 of R(N) into the accumulator. Opcodes AN and BN copy the accumulator into bits 7:0 and bits 15:8 of R(N), and leave the other byte unchanged.
- R9: Opcode F1 ORs memory at R(X) into the accumulator. Opcode F9 ORs memory at R(P) into it and adds 1 to R(P).
- R10: Pointer steps are modulo 2^16: FFFF plus 1 gives 0000, and 0000 minus 1 gives FFFF.
- R11: Opcodes 00, 3x, 6x (x not 0), 7x (x not 2 or 3), Cx, Dx, Ex, and Fx (x not 0, 1, 8 or 9) change no state and write no memory. They retire with `bad_op` high for that one cycle.
- R12: When `sel_load` is high at a clock edge, P takes `sel_p` and X takes `sel_x`. Otherwise both keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit can take an opcode |
| op_code | input | 8 | Opcode: bits 7:4 operation, bits 3:0 N |
| sel_load | input | 1 | Load both selectors this edge |
| sel_p | input | 4 | New program selector |
| sel_x | input | 4 | New index selector |
| mem_addr | output | 16 | Memory address (selected pointer) |
| mem_wdata | output | 8 | Memory write data (accumulator) |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, same cycle |
| acc_d | output | 8 | Accumulator |
| retire | output | 1 | One-cycle pulse when an opcode completes |
| bad_op | output | 1 | With `retire`: opcode was unsupported |

## Verification
The in-line assertions check the handshake timing on every cycle. After an acceptance `op_ready` falls, an execute cycle is always followed by a single `retire` pulse, `bad_op` never appears without `retire`, writes occur only in the execute cycle, and an unsupported opcode leaves the accumulator untouched. The data results can only be shown by the bench's scenarios, which compare each retirement against a reference model. These include which byte or pointer moved, wrap-around at FFFF and 0000, byte-half preservation, store contents read back from memory, and selector changes taking effect.

// File: rtl/ptr_exec_pkg.sv
package ptr_exec_pkg;
  localparam int NREG  = 16;
  localparam int SEL_W = $clog2(NREG);
  localparam int OPC_W = 8;

  typedef enum logic {ST_IDLE, ST_EXEC} st_e;
  typedef enum logic [1:0] {SRC_N, SRC_X, SRC_P} src_e;
  typedef enum logic [2:0] {RG_KEEP, RG_INC, RG_DEC, RG_LO, RG_HI} rg_e;
  typedef enum logic [2:0] {DA_KEEP, DA_MEM, DA_OR, DA_LO, DA_HI} da_e;

  typedef struct packed {
    logic legal;
    src_e src;
    rg_e  rg;
    da_e  da;
    logic wr;
  } uop_t;
endpackage

// File: rtl/ptr_exec_decode.sv
module ptr_exec_decode
  import ptr_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output uop_t             uop
);
  logic [3:0] hi;
  logic [3:0] lo;
  assign hi = opcode[7:4];
  assign lo = opcode[3:0];

  always_comb begin
    uop       = '0;
    uop.src   = SRC_N;
    uop.rg    = RG_KEEP;
    uop.da    = DA_KEEP;
    case (hi)
      4'h0: if (lo != 4'h0) begin uop.legal = 1'b1; uop.da = DA_MEM; end
      4'h1: begin uop.legal = 1'b1; uop.rg = RG_INC; end
      4'h2: begin uop.legal = 1'b1; uop.rg = RG_DEC; end
      4'h4: begin uop.legal = 1'b1; uop.da = DA_MEM; uop.rg = RG_INC; end
      4'h5: begin uop.legal = 1'b1; uop.wr = 1'b1; end
      4'h6: if (lo == 4'h0) begin
              uop.legal = 1'b1; uop.src = SRC_X; uop.rg = RG_INC;
            end
      4'h7: if (lo == 4'h2) begin
              uop.legal = 1'b1; uop.src = SRC_X; uop.da = DA_MEM; uop.rg = RG_INC;
            end else if (lo == 4'h3) begin
              uop.legal = 1'b1; uop.src = SRC_X; uop.wr = 1'b1; uop.rg = RG_DEC;
            end
      4'h8: begin uop.legal = 1'b1; uop.da = DA_LO; end
      4'h9: begin uop.legal = 1'b1; uop.da = DA_HI; end
      4'hA: begin uop.legal = 1'b1; uop.rg = RG_LO; end
      4'hB: begin uop.legal = 1'b1; uop.rg = RG_HI; end
      4'hF: case (lo)
              4'h0: begin uop.legal = 1'b1; uop.src = SRC_X; uop.da = DA_MEM; end
              4'h1: begin uop.legal = 1'b1; uop.src = SRC_X; uop.da = DA_OR; end
              4'h8: begin
                      uop.legal = 1'b1; uop.src = SRC_P; uop.da = DA_MEM; uop.rg = RG_INC;
                    end
              4'h9: begin
                      uop.legal = 1'b1; uop.src = SRC_P; uop.da = DA_OR; uop.rg = RG_INC;
                    end
              default: ;
            endcase
      default: ;
    endcase
  end
endmodule

// File: rtl/ptr_exec_regs.sv
module ptr_exec_regs #(
  parameter int AW = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ptr_exec_pkg::SEL_W-1:0] ridx,
  output logic [AW-1:0]                 rdata,
  input  logic                          we,
  input  logic [ptr_exec_pkg::SEL_W-1:0] widx,
  input  logic [AW-1:0]                 wdata
);
  import ptr_exec_pkg::*;
  logic [AW-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bank[i] <= '0;
      else if (we && widx == SEL_W'(i))    bank[i] <= wdata;
    end
  end

  assign rdata = bank[ridx];
endmodule

// File: rtl/ptr_exec_step.sv
module ptr_exec_step #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0]          cur,
  input  ptr_exec_pkg::rg_e      op,
  input  logic [DW-1:0]          d,
  output logic [AW-1:0]          nxt
);
  import ptr_exec_pkg::*;
  localparam int HW = AW - DW;

  always_comb begin
    case (op)
      RG_INC:  nxt = cur + AW'(1);
      RG_DEC:  nxt = cur - AW'(1);
      RG_LO:   nxt = {cur[AW-1:DW], d};
      RG_HI:   nxt = {d, cur[HW-1:0]};
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ptr_exec_unit.sv
module ptr_exec_unit #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [7:0]    op_code,
  input  logic          sel_load,
  input  logic [3:0]    sel_p,
  input  logic [3:0]    sel_x,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_d,
  output logic          retire,
  output logic          bad_op
);
  import ptr_exec_pkg::*;

  st_e              st;
  logic [OPC_W-1:0] op_q;
  logic [SEL_W-1:0] p_q, x_q, sel;
  logic [DW-1:0]    d_q, d_nxt;
  logic [AW-1:0]    cur, nxt;
  uop_t             u;
  logic             exec, reg_we;

  assign op_ready = (st == ST_IDLE);
  assign exec     = (st == ST_EXEC);

  ptr_exec_decode i_dec (.opcode(op_q), .uop(u));

  always_comb begin
    case (u.src)
      SRC_X:   sel = x_q;
      SRC_P:   sel = p_q;
      default: sel = op_q[SEL_W-1:0];
    endcase
  end

  assign reg_we = exec && u.legal && (u.rg != RG_KEEP);

  ptr_exec_regs #(.AW(AW)) i_regs (
    .clk(clk), .rst_n(rst_n), .ridx(sel), .rdata(cur),
    .we(reg_we), .widx(sel), .wdata(nxt)
  );

  ptr_exec_step #(.AW(AW), .DW(DW)) i_step (
    .cur(cur), .op(u.rg), .d(d_q), .nxt(nxt)
  );

  assign mem_addr  = cur;
  assign mem_wdata = d_q;
  assign mem_we    = exec && u.legal && u.wr;
  assign acc_d     = d_q;

  always_comb begin
    case (u.da)
      DA_MEM:  d_nxt = mem_rdata;
      DA_OR:   d_nxt = mem_rdata | d_q;
      DA_LO:   d_nxt = cur[DW-1:0];
      DA_HI:   d_nxt = cur[AW-1:AW-DW];
      default: d_nxt = d_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= '0;
      d_q    <= '0;
      retire <= 1'b0;
      bad_op <= 1'b0;
    end else begin
      retire <= exec;
      bad_op <= exec && !u.legal;
      if (exec) begin
        st <= ST_IDLE;
        if (u.legal) d_q <= d_nxt;
      end else if (op_valid) begin
        st   <= ST_EXEC;
        op_q <= op_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      x_q <= '0;
    end else if (sel_load) begin
      p_q <= sel_p;
      x_q <= sel_x;
    end
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !op_ready);
  // R2
  exec_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> retire);
  // R2
  retire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);
  // R11
  bad_needs_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> retire);
  // R11
  bad_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !u.legal) |=> $stable(acc_d));
  // R6
  write_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !op_ready);
  // R12
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_load |=> ($stable(p_q) && $stable(x_q)));
endmodule

// File: tb/test_ptr_exec_unit.sv
module test_ptr_exec_unit;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [7:0]  op_code = '0;
  logic        sel_load = 1'b0;
  logic [3:0]  sel_p = '0, sel_x = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, acc_d;
  logic        mem_we, retire, bad_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_exec_unit i_ptr_exec_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .sel_load(sel_load), .sel_p(sel_p), .sel_x(sel_x),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .acc_d(acc_d), .retire(retire), .bad_op(bad_op)
  );

  logic [7:0] mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  // reference model state
  logic [15:0] m_r [16];
  logic [7:0]  m_d;
  logic [3:0]  m_p, m_x;
  logic [7:0]  m_mem [256];

  int n_cmp = 0, n_bad = 0;
  logic [8:0] expq [$];
  string      tagq [$];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic model_op(input logic [7:0] op, output logic bad);
    logic [3:0] hi, lo;
    hi = op[7:4]; lo = op[3:0]; bad = 1'b0;
    case (hi)
      4'h0: if (lo != 0) m_d = m_mem[m_r[lo][7:0]]; else bad = 1'b1;
      4'h1: m_r[lo] = m_r[lo] + 16'd1;
      4'h2: m_r[lo] = m_r[lo] - 16'd1;
      4'h4: begin m_d = m_mem[m_r[lo][7:0]]; m_r[lo] = m_r[lo] + 16'd1; end
      4'h5: m_mem[m_r[lo][7:0]] = m_d;
      4'h6: if (lo == 0) m_r[m_x] = m_r[m_x] + 16'd1; else bad = 1'b1;
      4'h7: if (lo == 2) begin
              m_d = m_mem[m_r[m_x][7:0]]; m_r[m_x] = m_r[m_x] + 16'd1;
            end else if (lo == 3) begin
              m_mem[m_r[m_x][7:0]] = m_d; m_r[m_x] = m_r[m_x] - 16'd1;
            end else bad = 1'b1;
      4'h8: m_d = m_r[lo][7:0];
      4'h9: m_d = m_r[lo][15:8];
      4'hA: m_r[lo][7:0] = m_d;
      4'hB: m_r[lo][15:8] = m_d;
      4'hF: case (lo)
              4'h0: m_d = m_mem[m_r[m_x][7:0]];
              4'h1: m_d = m_d | m_mem[m_r[m_x][7:0]];
              4'h8: begin m_d = m_mem[m_r[m_p][7:0]]; m_r[m_p] = m_r[m_p] + 16'd1; end
              4'h9: begin m_d = m_d | m_mem[m_r[m_p][7:0]]; m_r[m_p] = m_r[m_p] + 16'd1; end
              default: bad = 1'b1;
            endcase
      default: bad = 1'b1;
    endcase
  endtask

  // driver: holds op_valid through the execute cycle (ready low) to probe back-pressure
  task automatic run_op(input logic [7:0] op, input string tag);
    logic bad;
    model_op(op, bad);
    expq.push_back({bad, m_d});
    tagq.push_back(tag);
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1;
    op_code  = op;
    @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && retire) begin
      if (expq.size() == 0) begin
        chk("R2 unexpected retire", 16'd1, 16'd0);
      end else begin
        logic [8:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({t, " acc"}, {8'h0, acc_d}, {8'h0, e[7:0]});
        chk({t, " bad_op"}, {15'h0, bad_op}, {15'h0, e[8]});
      end
    end
  end

  task automatic poke(input logic [7:0] a, input logic [7:0] v);
    mem[a] = v;
    m_mem[a] = v;
  endtask

  task automatic set_sel(input logic [3:0] p, input logic [3:0] x);
    @(negedge clk);
    sel_load = 1'b1; sel_p = p; sel_x = x;
    @(negedge clk);
    sel_load = 1'b0; sel_p = ~p; sel_x = ~x;
    m_p = p; m_x = x;
  endtask

  task automatic set_reg(input logic [3:0] n, input logic [15:0] v);
    poke(m_r[m_p][7:0], v[15:8]);
    run_op(8'hF8, "R5 setup hi");
    run_op(8'hB0 | {4'h0, n}, "R8 setup hi");
    poke(m_r[m_p][7:0], v[7:0]);
    run_op(8'hF8, "R5 setup lo");
    run_op(8'hA0 | {4'h0, n}, "R8 setup lo");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 16'd1, 16'd0);
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 5 + 1);
      m_mem[i] = 8'(i * 5 + 1);
    end
    for (int i = 0; i < 16; i++) m_r[i] = '0;
    m_d = '0; m_p = '0; m_x = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 acc", {8'h0, acc_d}, 16'h0);
    chk("R1 op_ready", {15'h0, op_ready}, 16'h1);
    chk("R1 retire", {15'h0, retire}, 16'h0);
    chk("R1 bad_op", {15'h0, bad_op}, 16'h0);
    run_op(8'h87, "R1 R7 zero");
    run_op(8'hF0, "R1 X=0 reads mem[R0]");

    // R12 selectors
    set_sel(4'h1, 4'h5);
    set_reg(4'h3, 16'h0020);
    set_reg(4'h5, 16'h0040);
    run_op(8'hF0, "R12 X now 5");

    // R3 loads via N
    run_op(8'h03, "R3 load via N");
    run_op(8'h43, "R3 load advance");
    run_op(8'h83, "R3 pointer advanced");

    // R6 store via N, read back
    run_op(8'h53, "R6 store via N");
    chk("R6 memory after store", {8'h0, mem[8'h21]}, {8'h0, m_mem[8'h21]});
    run_op(8'h13, "R7 inc");
    run_op(8'h23, "R7 dec");
    run_op(8'h03, "R6 readback");

    // R4 loads via X
    run_op(8'h72, "R4 load via X advance");
    run_op(8'h85, "R4 X advanced");
    run_op(8'h60, "R7 inc X");
    run_op(8'h85, "R7 X after inc");
    poke(8'h00, 8'h5A);
    run_op(8'h73, "R6 store via X dec");
    chk("R6 memory after X store", {8'h0, mem[8'h42]}, {8'h0, m_mem[8'h42]});
    run_op(8'h85, "R6 X decremented");
    run_op(8'hF0, "R4 load via X");

    // R9 OR
    poke(8'h41, 8'h0F);
    run_op(8'hF8, "R5 immediate");
    run_op(8'hF1, "R9 or via X");
    poke(m_r[m_p][7:0], 8'hC0);
    run_op(8'hF9, "R9 or immediate");
    run_op(8'h81, "R9 P advanced");

    // R10 wrap
    set_reg(4'h4, 16'hFFFF);
    run_op(8'h14, "R10 inc wraps");
    run_op(8'h94, "R10 hi after wrap");
    run_op(8'h84, "R10 lo after wrap");
    run_op(8'h24, "R10 dec wraps");
    run_op(8'h94, "R10 hi after dec");

    // R8 byte halves
    set_reg(4'h6, 16'h1234);
    poke(m_r[m_p][7:0], 8'hA5);
    run_op(8'hF8, "R5 imm");
    run_op(8'hA6, "R8 put low");
    run_op(8'h96, "R8 high kept");
    run_op(8'h86, "R8 low written");
    run_op(8'hB6, "R8 put high");
    run_op(8'h86, "R8 low kept");

    // R11 unsupported
    run_op(8'h00, "R11 op 00");
    run_op(8'h30, "R11 op 30");
    run_op(8'h61, "R11 op 61");
    run_op(8'h75, "R11 op 75");
    run_op(8'hC3, "R11 op C3");
    run_op(8'hE0, "R11 op E0");
    run_op(8'hFA, "R11 op FA");
    run_op(8'h85, "R11 X ptr kept");
    run_op(8'h83, "R11 R3 kept");
    chk("R11 memory kept", {8'h0, mem[8'h42]}, {8'h0, m_mem[8'h42]});

    repeat (3) @(negedge clk);
    chk("R2 all retired", 16'(expq.size()), 16'd0);
    report();
    $finish;
  end
endmodule